// File: doc/BRIEF.md
# Three-Phase Min-Max Offset Injector

This block receives a set of three signed phase reference samples together with a valid strobe. From each set it forms a common-mode term: the midpoint between the largest and the smallest of the three samples. It subtracts that term from every phase. The three results are flattened modulation waveforms that feed three multicarrier modulators.

The injected term is the same for all three phases, so the line-to-line voltages of a three-wire load stay the same. The peak of each result drops to about 0.87 of the input amplitude. A reference can therefore be driven roughly 15% higher before any modulator input reaches its limit. Samples enter and leave through valid/ready handshakes. A two-stage pipeline accepts one sample set per cycle. The first stage finds the extremes and the second stage subtracts the offset.

Top module: `minmax_offset_inj`

## Requirements
- R1: For each accepted set (a, b, c) of 16-bit signed samples, the offset is floor((max + min) / 2), computed from a 17-bit sum. Each output equals its own input minus this offset. Output a, b and c map to input a, b and c.
- R2: When no output saturates, every difference between two outputs equals the difference between the matching inputs exactly.
- R3: An output whose exact value does not fit in 16 bits is clamped to +32767 or −32768. A sticky clip flag is then set and stays set until reset. Without an overflow the flag stays low.
- R4: With out_ready held high, a set accepted at one rising edge appears with out_valid high after the second rising edge. Back-to-back sets are accepted one per cycle, and outputs come out in input order.
- R5: While out_valid is high and out_ready is low, out_valid and all three outputs hold their values.
- R6: When both pipeline stages hold data and out_ready is low, in_ready is low, and no set is lost or duplicated.
- R7: When two or three inputs are equal, the outputs still follow R1. Three equal inputs give three zero outputs.
- R8: While reset is high, and in the cycle after it, out_valid and clip are low.
- R9: For balanced three-phase inputs of amplitude 1.15 × L with L = 24000, no output magnitude exceeds L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample set is valid |
| in_ready | output | 1 | Block can accept a set this cycle |
| in_a | input | 16 | Phase a reference, signed |
| in_b | input | 16 | Phase b reference, signed |
| in_c | input | 16 | Phase c reference, signed |
| out_valid | output | 1 | Output set is valid |
| out_ready | input | 1 | Downstream accepts the output set |
| out_a | output | 16 | Phase a modulation waveform, signed |
| out_b | output | 16 | Phase b modulation waveform, signed |
| out_c | output | 16 | Phase c modulation waveform, signed |
| clip | output | 1 | Sticky flag: some output was saturated |

## Verification
The bench targets odd sums of max and min, where the offset must round toward minus infinity. A design that truncates toward zero gives outputs one step off for negative sums. It drives the single input set that can overflow, +32767 together with −32768. A design without a wide enough difference or without clamping wraps that output to a large negative value, and the clip flag never rises. It holds out_ready low while the pipeline is full. A design with a wrong ready chain drops a set or repeats one, which breaks the order and the count of outputs. Sets with ties and balanced sinusoids at 1.15 × L test the tie logic, the R2 line-to-line difference and the R9 headroom claim.

// File: rtl/mmoi_pkg.sv
package mmoi_pkg;

    localparam int DATA_W = 16;
    localparam int NPH    = 3;
    localparam int SUM_W  = DATA_W + 1;
    localparam int DIFF_W = DATA_W + 2;

    typedef logic signed [DATA_W-1:0] smp_t;
    typedef logic signed [SUM_W-1:0]  sum_t;
    typedef logic signed [DIFF_W-1:0] dif_t;
    typedef logic [NPH-1:0][DATA_W-1:0] phv_t;

    typedef struct packed {
        phv_t ph;
        smp_t hi;
        smp_t lo;
    } ext_t;

    localparam smp_t SMP_MAX = smp_t'({1'b0, {(DATA_W-1){1'b1}}});
    localparam smp_t SMP_MIN = smp_t'({1'b1, {(DATA_W-1){1'b0}}});

    function automatic sum_t mid_of(input smp_t hi, input smp_t lo);
        sum_t s;
        s = SUM_W'(hi) + SUM_W'(lo);
        return s >>> 1;
    endfunction

    function automatic logic fits(input dif_t v);
        return (v <= DIFF_W'(SMP_MAX)) && (v >= DIFF_W'(SMP_MIN));
    endfunction

    function automatic smp_t clamp(input dif_t v);
        if (v > DIFF_W'(SMP_MAX)) return SMP_MAX;
        if (v < DIFF_W'(SMP_MIN)) return SMP_MIN;
        return v[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/mmoi_extrema.sv
module mmoi_extrema
    import mmoi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic in_ready,
    input  phv_t in_ph,
    output logic s1_valid,
    output ext_t s1_q,
    input  logic dn_ready
);

    smp_t hi_c;
    smp_t lo_c;
    logic v_q;
    ext_t q;

    always_comb begin
        hi_c = $signed(in_ph[0]);
        lo_c = $signed(in_ph[0]);
        for (int i = 1; i < NPH; i++) begin
            if ($signed(in_ph[i]) > hi_c) hi_c = $signed(in_ph[i]);
            if ($signed(in_ph[i]) < lo_c) lo_c = $signed(in_ph[i]);
        end
    end

    assign in_ready = !v_q || dn_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= 1'b0;
            q   <= '0;
        end else if (in_ready) begin
            v_q <= in_valid;
            if (in_valid) begin
                q.ph <= in_ph;
                q.hi <= hi_c;
                q.lo <= lo_c;
            end
        end
    end

    assign s1_valid = v_q;
    assign s1_q     = q;

    // R6: a stalled first-stage entry is neither lost nor changed
    a_r6_s1_hold: assert property (@(posedge clk) disable iff (rst)
        (v_q && !dn_ready) |=> (v_q && $stable(q)));

    // R7: every stored phase lies between the stored extremes
    generate
        for (genvar g = 0; g < NPH; g++) begin : g_rng
            a_r7_in_range: assert property (@(posedge clk) disable iff (rst)
                v_q |-> (($signed(q.ph[g]) <= $signed(q.hi)) &&
                         ($signed(q.ph[g]) >= $signed(q.lo))));
        end
    endgenerate

endmodule

// File: rtl/mmoi_offset_sub.sv
module mmoi_offset_sub
    import mmoi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic s1_valid,
    input  ext_t s1_q,
    output logic s2_ready,
    output logic out_valid,
    input  logic out_ready,
    output phv_t out_ph,
    output logic clip
);

    sum_t           mid;
    phv_t           nxt;
    logic [NPH-1:0] ovf;
    logic           ov_q;
    logic           sat_q;
    logic           clip_q;
    phv_t           oq;

    assign mid = mid_of(s1_q.hi, s1_q.lo);

    generate
        for (genvar k = 0; k < NPH; k++) begin : g_sub
            dif_t d;
            assign d      = DIFF_W'($signed(s1_q.ph[k])) - DIFF_W'(mid);
            assign nxt[k] = clamp(d);
            assign ovf[k] = !fits(d);
        end
    endgenerate

    assign s2_ready = !ov_q || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            ov_q   <= 1'b0;
            sat_q  <= 1'b0;
            clip_q <= 1'b0;
            oq     <= '0;
        end else begin
            if (s2_ready) begin
                ov_q <= s1_valid;
                if (s1_valid) begin
                    oq    <= nxt;
                    sat_q <= |ovf;
                end
            end
            if (s1_valid && s2_ready && (|ovf)) clip_q <= 1'b1;
        end
    end

    assign out_valid = ov_q;
    assign out_ph    = oq;
    assign clip      = clip_q;

    // helper for the checks below: extremes of the registered outputs
    smp_t omx;
    smp_t omn;
    always_comb begin
        omx = $signed(oq[0]);
        omn = $signed(oq[0]);
        for (int i = 1; i < NPH; i++) begin
            if ($signed(oq[i]) > omx) omx = $signed(oq[i]);
            if ($signed(oq[i]) < omn) omn = $signed(oq[i]);
        end
    end

    // R5: output held under backpressure
    a_r5_out_hold: assert property (@(posedge clk) disable iff (rst)
        (ov_q && !out_ready) |=> (ov_q && $stable(oq)));

    // R3: clip flag never falls outside reset
    a_r3_clip_sticky: assert property (@(posedge clk) disable iff (rst)
        clip_q |=> clip_q);

    // R3: clip rises only with a clamped output on the port
    a_r3_clip_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(clip_q) |-> (ov_q && ((omx == SMP_MAX) || (omn == SMP_MIN))));

    // R1: unclamped outputs are centred, so max+min is 0 or 1
    a_r1_centred: assert property (@(posedge clk) disable iff (rst)
        (ov_q && !sat_q) |->
            (((SUM_W'(omx) + SUM_W'(omn)) == sum_t'(0)) ||
             ((SUM_W'(omx) + SUM_W'(omn)) == sum_t'(1))));

    // R4: an output only appears after a first-stage entry
    a_r4_flow: assert property (@(posedge clk) disable iff (rst)
        $rose(ov_q) |-> $past(s1_valid));

endmodule

// File: rtl/minmax_offset_inj.sv
module minmax_offset_inj
    import mmoi_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [15:0] in_a,
    input  logic [15:0] in_b,
    input  logic [15:0] in_c,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [15:0] out_a,
    output logic [15:0] out_b,
    output logic [15:0] out_c,
    output logic        clip
);

    phv_t in_ph;
    phv_t out_ph;
    ext_t s1_q;
    logic s1_valid;
    logic s2_ready;

    assign in_ph = {in_c, in_b, in_a};

    mmoi_extrema u_ext (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_ph    (in_ph),
        .s1_valid (s1_valid),
        .s1_q     (s1_q),
        .dn_ready (s2_ready)
    );

    mmoi_offset_sub u_sub (
        .clk       (clk),
        .rst       (rst),
        .s1_valid  (s1_valid),
        .s1_q      (s1_q),
        .s2_ready  (s2_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_ph    (out_ph),
        .clip      (clip)
    );

    assign out_a = out_ph[0];
    assign out_b = out_ph[1];
    assign out_c = out_ph[2];

    // R8: nothing valid and no clip in the cycle after reset
    a_r8_reset: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !clip));

endmodule

// File: tb/test_minmax_offset_inj.sv
module test_minmax_offset_inj;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_a = '0, in_b = '0, in_c = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_a, out_b, out_c;
    logic        clip;

    minmax_offset_inj i_minmax_offset_inj (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_a(out_a), .out_b(out_b), .out_c(out_c), .clip(clip)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    int    ea[256], eb[256], ec[256], xa[256], xb[256], xc[256];
    bit    ek[256];
    string et[256];
    int    wp = 0, rp = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int sat16(input int v, output bit k);
        k = 0;
        if (v > 32767)  begin k = 1; return 32767;  end
        if (v < -32768) begin k = 1; return -32768; end
        return v;
    endfunction

    task automatic push(input int a, input int b, input int c, input string tag);
        int mx, mn, s, off;
        bit k1, k2, k3;
        mx = a; mn = a;
        if (b > mx) mx = b;
        if (c > mx) mx = c;
        if (b < mn) mn = b;
        if (c < mn) mn = c;
        s   = mx + mn;
        off = (s >= 0) ? s / 2 : -((1 - s) / 2);
        ea[wp % 256] = sat16(a - off, k1);
        eb[wp % 256] = sat16(b - off, k2);
        ec[wp % 256] = sat16(c - off, k3);
        ek[wp % 256] = k1 | k2 | k3;
        xa[wp % 256] = a; xb[wp % 256] = b; xc[wp % 256] = c;
        et[wp % 256] = tag;
        wp++;
    endtask

    // called at a falling edge; returns at a later falling edge after acceptance
    task automatic send(input int a, input int b, input int c, input string tag);
        push(a, b, c, tag);
        in_a = 16'(a); in_b = 16'(b); in_c = 16'(c);
        in_valid = 1'b1;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 30 && rp != wp; i++) @(negedge clk);
        chk(rp == wp, "R4", "outputs missing", wp - rp, 0);
        @(negedge clk);
    endtask

    // output monitor, samples well after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (!rst && out_valid && out_ready) begin
                if (rp == wp) begin
                    chk(0, "R6", "unexpected extra output", rp, wp);
                end else begin
                    int i, oa, ob, oc;
                    i  = rp % 256;
                    oa = $signed(out_a); ob = $signed(out_b); oc = $signed(out_c);
                    chk(oa == ea[i], et[i], "out_a", oa, ea[i]);
                    chk(ob == eb[i], et[i], "out_b", ob, eb[i]);
                    chk(oc == ec[i], et[i], "out_c", oc, ec[i]);
                    if (!ek[i]) begin
                        chk(oa - ob == xa[i] - xb[i], "R2", "a-b difference", oa - ob, xa[i] - xb[i]);
                        chk(ob - oc == xb[i] - xc[i], "R2", "b-c difference", ob - oc, xb[i] - xc[i]);
                    end
                    if (et[i] == "R9") begin
                        chk(oa <= 24000 && oa >= -24000, "R9", "|out_a| headroom", oa, 24000);
                        chk(ob <= 24000 && ob >= -24000, "R9", "|out_b| headroom", ob, 24000);
                        chk(oc <= 24000 && oc >= -24000, "R9", "|out_c| headroom", oc, 24000);
                    end
                    rp++;
                end
            end
        end
    end

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 0, "R8", "out_valid in reset", out_valid, 0);
        chk(clip == 0, "R8", "clip in reset", clip, 0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(out_valid == 0, "R8", "out_valid after reset", out_valid, 0);
        chk(clip == 0, "R8", "clip after reset", clip, 0);
        @(negedge clk);
    endtask

    task automatic t_latency();
        push(1000, -200, 50, "R4");
        in_a = 16'(1000); in_b = 16'(-200); in_c = 16'(50);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        #2;
        chk(out_valid == 0, "R4", "out_valid after one edge", out_valid, 0);
        @(negedge clk);
        #2;
        chk(out_valid == 1, "R4", "out_valid after two edges", out_valid, 1);
        drain();
    endtask

    task automatic t_stream();
        int t0;
        t0 = cyc;
        for (int k = 0; k < 10; k++)
            send(k * 3117 - 15000, 9000 - k * 1777, (k % 2 == 0) ? 4321 : -4321, "R1");
        chk(cyc - t0 == 10, "R4", "cycles for 10 sets", cyc - t0, 10);
        drain();
    endtask

    task automatic t_rounding();
        send(3, 0, 0, "R1");
        send(-3, 0, 0, "R1");
        send(-32768, -32767, -1, "R1");
        send(-7, 12, -20001, "R1");
        drain();
    endtask

    task automatic t_ties();
        send(5, 5, 5, "R7");
        send(-32768, -32768, -32768, "R7");
        send(100, 100, -50, "R7");
        send(-9, 40, -9, "R7");
        drain();
        chk(clip == 0, "R3", "clip without overflow", clip, 0);
    endtask

    task automatic t_clip();
        send(32767, -32768, 0, "R3");
        drain();
        chk(clip == 1, "R3", "clip after overflow", clip, 1);
        send(10, 20, 30, "R3");
        drain();
        chk(clip == 1, "R3", "clip stays set", clip, 1);
    endtask

    task automatic t_backpressure();
        int ha, hb, hc;
        out_ready = 1'b0;
        send(2000, -1000, 500, "R5");
        send(-3000, 7000, 1, "R5");
        push(111, 222, -333, "R6");
        in_a = 16'(111); in_b = 16'(222); in_c = 16'(-333);
        in_valid = 1'b1;
        #1;
        chk(in_ready == 0, "R6", "in_ready with full pipeline", in_ready, 0);
        ha = out_a; hb = out_b; hc = out_c;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1;
            chk(in_ready == 0, "R6", "in_ready still low", in_ready, 0);
            chk(out_valid == 1, "R5", "out_valid held", out_valid, 1);
            chk(out_a == ha && out_b == hb && out_c == hc, "R5", "output held", out_a, ha);
        end
        @(negedge clk);
        out_ready = 1'b1;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        in_valid = 1'b0;
        drain();
    endtask

    task automatic t_headroom();
        real amp, th;
        amp = 27600.0;
        for (int k = 0; k < 12; k++) begin
            th = (k * 30.0 + 7.0) * 3.14159265358979 / 180.0;
            send($rtoi(amp * $sin(th)),
                 $rtoi(amp * $sin(th - 2.0943951023932)),
                 $rtoi(amp * $sin(th + 2.0943951023932)), "R9");
        end
        drain();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        chk(0, "R4", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_latency();
        t_stream();
        t_rounding();
        t_ties();
        t_backpressure();
        t_headroom();
        t_clip();
        t_reset();
        finish_run();
    end

endmodule